// File: doc/BRIEF.md
# Audio Sample Buffer with Word/Sample Format Conversion

This block holds audio samples on their way between a 32-bit word port, fed by a processor or a DMA engine, and a 20-bit sample path inside a codec interface. The transmit direction accepts 32-bit words. It takes the sample bits from either the top or the bottom of each word, depending on a justification mode. The result is stored as a 20-bit sample and presented at the head of the transmit queue. The receive direction stores 20-bit samples from the codec side. Each one leaves as a 32-bit word, formatted by one of four packing modes. The packing is applied when the word is read, so a mode change also affects samples already queued.

A single control register holds both request thresholds, both format modes and two flush bits that clear themselves. Each direction raises a request line that can drive an interrupt or a DMA channel. The transmit request means "enough room to refill". The receive request means "enough samples to drain". Pushing into a full queue or popping an empty one does nothing to the data, but it sets a sticky error flag.

Top module: `audio_sample_fifo`

## Requirements
- R1: Writing 1 to ctl bit 16 (TX flush) or ctl bit 17 (RX flush) sets that bit for one cycle, as seen on `ctl_rdata`. On the next clock edge the matching queue becomes empty, its sticky flags clear and the bit returns to 0. A push or pop in that same cycle is discarded.
- R2: Control layout: [7:0] TX threshold, [12:8] RX threshold, [13] TX justification, [15:14] RX packing mode. After reset `ctl_rdata` reads 0x00F30 (TX threshold 0x30, RX threshold 0x0F, all else 0).
- R3: With ctl bit 13 = 0 (top-justified input), a pushed word W becomes the stored sample {W[31:14], 2'b00}.
- R4: With ctl bit 13 = 1 (bottom-justified input), a pushed word W becomes {W[17:0], 2'b00}. The mode is applied when the word is pushed.
- R5: RX mode 0 reads a stored sample S as {S[19:2], 14'h0}. Mode 1 reads it as {14 copies of S[19], S[19:2]}.
- R6: RX mode 2 reads S as {S[19:4], 16'h0}. Mode 3 reads it as {16 copies of S[19], S[19:4]}. The mode in force at read time applies.
- R7: `tx_req` is high exactly when (64 - TX fill count) is at least the TX threshold field.
- R8: `rx_req` is high exactly when the RX fill count is at least the RX threshold field plus one.
- R9: Each queue returns samples in push order. The TX queue holds 64 entries and the RX queue holds 32. The empty and full outputs track the fill count.
- R10: A push into a full queue is discarded and sets that queue's sticky overrun flag. The flag stays set until a flush or reset.
- R11: A pop from an empty queue is discarded and sets that queue's sticky underrun flag. The flag stays set until a flush or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 18 | Control register write value |
| ctl_rdata | output | 18 | Control register contents |
| tx_wr_en | input | 1 | Push a word into the TX queue |
| tx_wr_data | input | 32 | Word to push |
| tx_rd_en | input | 1 | Pop the TX head sample |
| tx_sample | output | 20 | TX head sample |
| tx_empty | output | 1 | TX queue empty |
| tx_full | output | 1 | TX queue full |
| tx_req | output | 1 | TX refill request |
| tx_overrun | output | 1 | Sticky TX push-while-full flag |
| tx_underrun | output | 1 | Sticky TX pop-while-empty flag |
| rx_wr_en | input | 1 | Push a sample into the RX queue |
| rx_wr_sample | input | 20 | Sample to push |
| rx_rd_en | input | 1 | Pop the RX head word |
| rx_rd_data | output | 32 | RX head sample packed per mode |
| rx_empty | output | 1 | RX queue empty |
| rx_full | output | 1 | RX queue full |
| rx_req | output | 1 | RX drain request |
| rx_overrun | output | 1 | Sticky RX push-while-full flag |
| rx_underrun | output | 1 | Sticky RX pop-while-empty flag |

## Verification
The bench targets the threshold edges. At the reset TX threshold the request must drop between 16 and 17 stored words. At the reset RX threshold it must rise on the 16th sample, not the 15th. An off-by-one in either encoding shifts that edge by one entry. Both queues are filled past capacity and popped while empty. A design that wrapped its pointers would then return a wrong sample or lose its sticky flag. A push issued in the cycle a flush takes effect must be discarded. The RX packing modes are tested with a negative and a positive sample, which catches a swapped half-word or a zero fill put where a sign fill belongs.

// File: rtl/afmt_pkg.sv
package afmt_pkg;
   typedef enum logic [1:0] {
      PACK_TOP_ZERO = 2'd0,
      PACK_LOW_SIGN = 2'd1,
      PACK_HI_HALF  = 2'd2,
      PACK_LO_HALF  = 2'd3
   } rx_pack_e;
endpackage

// File: rtl/asf_ctl.sv
module asf_ctl #(
   parameter int CTL_W   = 18,
   parameter int TXF_BIT = 16,
   parameter int RXF_BIT = 17,
   parameter logic [CTL_W-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CTL_W-1:0] wdata,
   output logic [CTL_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RST_VAL;
      end else if (we) begin
         q <= wdata;
      end else begin
         q[TXF_BIT] <= 1'b0;
         q[RXF_BIT] <= 1'b0;
      end
   end
endmodule

// File: rtl/sfifo_core.sv
module sfifo_core #(
   parameter int DEPTH = 64,
   parameter int W     = 20,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full,
   output logic          overrun,
   output logic          underrun
);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   generate
      if (DEPTH != (1 << AW)) begin : g_bad_depth
         $error("sfifo_core: DEPTH must be a power of two");
      end
      if (DEPTH < 2) begin : g_small_depth
         $error("sfifo_core: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          push_ok, pop_ok;

   assign empty   = (count == '0);
   assign full    = (count == FULL_CNT);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (push_ok && !flush) begin
         mem[wp] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp       <= '0;
         rp       <= '0;
         count    <= '0;
         overrun  <= 1'b0;
         underrun <= 1'b0;
      end else if (flush) begin
         wp       <= '0;
         rp       <= '0;
         count    <= '0;
         overrun  <= 1'b0;
         underrun <= 1'b0;
      end else begin
         if (push_ok) wp <= wp + 1'b1;
         if (pop_ok)  rp <= rp + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         if (push && full)  overrun  <= 1'b1;
         if (pop && empty)  underrun <= 1'b1;
      end
   end
endmodule

// File: rtl/tx_unpack.sv
module tx_unpack #(
   parameter int WORD_W   = 32,
   parameter int SAMPLE_W = 20,
   parameter int RES      = 18,
   localparam int PAD     = SAMPLE_W - RES
) (
   input  logic [WORD_W-1:0]   word,
   input  logic                lsb_mode,
   output logic [SAMPLE_W-1:0] sample
);
   logic [RES-1:0] picked;

   always_comb begin
      if (lsb_mode) picked = word[RES-1:0];
      else          picked = word[WORD_W-1 -: RES];
   end

   generate
      if (PAD > 0) begin : g_pad
         assign sample = {picked, {PAD{1'b0}}};
      end else begin : g_nopad
         assign sample = picked;
      end
   endgenerate
endmodule

// File: rtl/rx_pack.sv
module rx_pack
   import afmt_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int SAMPLE_W = 20,
   parameter int RES      = 18,
   localparam int HALF    = WORD_W / 2,
   localparam int FILL    = WORD_W - RES,
   localparam int DROP    = SAMPLE_W - RES
) (
   input  logic [SAMPLE_W-1:0] sample,
   input  rx_pack_e            mode,
   output logic [WORD_W-1:0]   word
);
   logic [RES-1:0]  top_bits;
   logic [HALF-1:0] half_bits;
   logic            sgn;

   assign top_bits  = sample[SAMPLE_W-1 -: RES];
   assign half_bits = sample[SAMPLE_W-1 -: HALF];
   assign sgn       = sample[SAMPLE_W-1];

   generate
      if (DROP > 0) begin : g_drop
         logic unused_low_bits;
         assign unused_low_bits = ^sample[DROP-1:0];
      end
   endgenerate

   always_comb begin
      unique case (mode)
         PACK_TOP_ZERO: word = {top_bits, {FILL{1'b0}}};
         PACK_LOW_SIGN: word = {{FILL{sgn}}, top_bits};
         PACK_HI_HALF:  word = {half_bits, {HALF{1'b0}}};
         PACK_LO_HALF:  word = {{HALF{sgn}}, half_bits};
         default:       word = '0;
      endcase
   end
endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo
   import afmt_pkg::*;
#(
   parameter int TX_DEPTH   = 64,
   parameter int RX_DEPTH   = 32,
   parameter int WORD_W     = 32,
   parameter int SAMPLE_W   = 20,
   parameter int SAMPLE_RES = 18,
   parameter int TXL_W      = 8,
   parameter int RXL_W      = 5,
   parameter int TX_LVL_RST = 48,
   parameter int RX_LVL_RST = 15,
   localparam int TXC_W     = $clog2(TX_DEPTH) + 1,
   localparam int RXC_W     = $clog2(RX_DEPTH) + 1,
   localparam int RXL_LO    = TXL_W,
   localparam int TXM_BIT   = TXL_W + RXL_W,
   localparam int RXM_LO    = TXM_BIT + 1,
   localparam int TXF_BIT   = RXM_LO + 2,
   localparam int RXF_BIT   = TXF_BIT + 1,
   localparam int CTL_W     = RXF_BIT + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ctl_we,
   input  logic [CTL_W-1:0]    ctl_wdata,
   output logic [CTL_W-1:0]    ctl_rdata,
   input  logic                tx_wr_en,
   input  logic [WORD_W-1:0]   tx_wr_data,
   input  logic                tx_rd_en,
   output logic [SAMPLE_W-1:0] tx_sample,
   output logic                tx_empty,
   output logic                tx_full,
   output logic                tx_req,
   output logic                tx_overrun,
   output logic                tx_underrun,
   input  logic                rx_wr_en,
   input  logic [SAMPLE_W-1:0] rx_wr_sample,
   input  logic                rx_rd_en,
   output logic [WORD_W-1:0]   rx_rd_data,
   output logic                rx_empty,
   output logic                rx_full,
   output logic                rx_req,
   output logic                rx_overrun,
   output logic                rx_underrun
);
   localparam logic [CTL_W-1:0] CTL_RST =
      CTL_W'(TX_LVL_RST) | (CTL_W'(RX_LVL_RST) << RXL_LO);

   generate
      if (SAMPLE_RES > SAMPLE_W) begin : g_bad_res
         $error("audio_sample_fifo: SAMPLE_RES exceeds SAMPLE_W");
      end
      if (SAMPLE_W < WORD_W / 2 || SAMPLE_W >= WORD_W) begin : g_bad_width
         $error("audio_sample_fifo: SAMPLE_W must lie in [WORD_W/2, WORD_W)");
      end
      if (TX_LVL_RST >= (1 << TXL_W) || RX_LVL_RST >= (1 << RXL_W)) begin : g_bad_lvl
         $error("audio_sample_fifo: threshold reset value does not fit its field");
      end
   endgenerate

   logic [CTL_W-1:0]    ctl;
   logic [TXL_W-1:0]    tx_lvl;
   logic [RXL_W-1:0]    rx_lvl;
   logic                tx_lsb;
   rx_pack_e            rx_mode;
   logic [SAMPLE_W-1:0] tx_in_sample;
   logic [SAMPLE_W-1:0] rx_head;
   logic [TXC_W-1:0]    tx_cnt;
   logic [RXC_W-1:0]    rx_cnt;

   asf_ctl #(
      .CTL_W   (CTL_W),
      .TXF_BIT (TXF_BIT),
      .RXF_BIT (RXF_BIT),
      .RST_VAL (CTL_RST)
   ) u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ctl_we),
      .wdata (ctl_wdata),
      .q     (ctl)
   );

   assign ctl_rdata = ctl;
   assign tx_lvl    = ctl[TXL_W-1:0];
   assign rx_lvl    = ctl[RXL_LO +: RXL_W];
   assign tx_lsb    = ctl[TXM_BIT];
   assign rx_mode   = rx_pack_e'(ctl[RXM_LO +: 2]);

   tx_unpack #(
      .WORD_W   (WORD_W),
      .SAMPLE_W (SAMPLE_W),
      .RES      (SAMPLE_RES)
   ) u_unpack (
      .word     (tx_wr_data),
      .lsb_mode (tx_lsb),
      .sample   (tx_in_sample)
   );

   sfifo_core #(
      .DEPTH (TX_DEPTH),
      .W     (SAMPLE_W)
   ) u_tx_q (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (ctl[TXF_BIT]),
      .push     (tx_wr_en),
      .pop      (tx_rd_en),
      .din      (tx_in_sample),
      .dout     (tx_sample),
      .count    (tx_cnt),
      .empty    (tx_empty),
      .full     (tx_full),
      .overrun  (tx_overrun),
      .underrun (tx_underrun)
   );

   sfifo_core #(
      .DEPTH (RX_DEPTH),
      .W     (SAMPLE_W)
   ) u_rx_q (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (ctl[RXF_BIT]),
      .push     (rx_wr_en),
      .pop      (rx_rd_en),
      .din      (rx_wr_sample),
      .dout     (rx_head),
      .count    (rx_cnt),
      .empty    (rx_empty),
      .full     (rx_full),
      .overrun  (rx_overrun),
      .underrun (rx_underrun)
   );

   rx_pack #(
      .WORD_W   (WORD_W),
      .SAMPLE_W (SAMPLE_W),
      .RES      (SAMPLE_RES)
   ) u_pack (
      .sample (rx_head),
      .mode   (rx_mode),
      .word   (rx_rd_data)
   );

   logic [31:0] tx_free;
   assign tx_free = 32'(TX_DEPTH) - 32'(tx_cnt);
   assign tx_req  = (tx_free >= 32'(tx_lvl));
   assign rx_req  = (32'(rx_cnt) >= (32'(rx_lvl) + 32'd1));
endmodule

// File: rtl/asf_checker.sv
module asf_checker #(
   parameter int TX_DEPTH = 64,
   parameter int CTL_W    = 18,
   parameter int TXF_BIT  = 16,
   parameter int RXF_BIT  = 17,
   parameter int RXM_LO   = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_we,
   input logic [CTL_W-1:0] ctl_rdata,
   input logic             tx_empty,
   input logic             tx_req,
   input logic             tx_overrun,
   input logic             tx_underrun,
   input logic             rx_empty,
   input logic             rx_req,
   input logic             rx_overrun,
   input logic             rx_underrun,
   input logic [31:0]      rx_rd_data
);
   logic [1:0] mode;
   assign mode = ctl_rdata[RXM_LO +: 2];

   AST_TX_FLUSH_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[TXF_BIT] && !ctl_we |=> !ctl_rdata[TXF_BIT]); // R1
   AST_RX_FLUSH_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[RXF_BIT] && !ctl_we |=> !ctl_rdata[RXF_BIT]); // R1
   AST_TX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[TXF_BIT] |=> tx_empty && !tx_overrun && !tx_underrun); // R1
   AST_RX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[RXF_BIT] |=> rx_empty && !rx_overrun && !rx_underrun); // R1
   AST_TX_REQ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty && (32'(ctl_rdata[7:0]) <= 32'(TX_DEPTH)) |-> tx_req); // R7
   AST_RX_NO_REQ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_empty |-> !rx_req); // R8
   AST_TX_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_overrun && !ctl_rdata[TXF_BIT] |=> tx_overrun); // R10
   AST_RX_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun && !ctl_rdata[RXF_BIT] |=> rx_overrun); // R10
   AST_TX_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_underrun && !ctl_rdata[TXF_BIT] |=> tx_underrun); // R11
   AST_RX_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_underrun && !ctl_rdata[RXF_BIT] |=> rx_underrun); // R11
   AST_RX_TOP_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      mode == 2'd0 |-> rx_rd_data[13:0] == 14'h0); // R5
   AST_RX_HI_HALF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      mode == 2'd2 |-> rx_rd_data[15:0] == 16'h0); // R6
   AST_RX_LO_HALF_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      mode == 2'd3 |-> rx_rd_data[31:16] == {16{rx_rd_data[15]}}); // R6
endmodule

bind audio_sample_fifo asf_checker u_asf_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctl_we      (ctl_we),
   .ctl_rdata   (ctl_rdata),
   .tx_empty    (tx_empty),
   .tx_req      (tx_req),
   .tx_overrun  (tx_overrun),
   .tx_underrun (tx_underrun),
   .rx_empty    (rx_empty),
   .rx_req      (rx_req),
   .rx_overrun  (rx_overrun),
   .rx_underrun (rx_underrun),
   .rx_rd_data  (rx_rd_data)
);

// File: tb/test_audio_sample_fifo.sv
`timescale 1ns/1ps
module test_audio_sample_fifo;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 1'b0;
   logic [17:0] ctl_wdata = '0;
   logic [17:0] ctl_rdata;
   logic        tx_wr_en = 1'b0;
   logic [31:0] tx_wr_data = '0;
   logic        tx_rd_en = 1'b0;
   logic [19:0] tx_sample;
   logic        tx_empty, tx_full, tx_req, tx_overrun, tx_underrun;
   logic        rx_wr_en = 1'b0;
   logic [19:0] rx_wr_sample = '0;
   logic        rx_rd_en = 1'b0;
   logic [31:0] rx_rd_data;
   logic        rx_empty, rx_full, rx_req, rx_overrun, rx_underrun;

   int n_tests = 0;
   int n_fail  = 0;
   logic [19:0] txq [$];
   logic [19:0] rxq [$];
   logic [17:0] shadow;

   always #10 clk = ~clk;

   audio_sample_fifo i_audio_sample_fifo (.*);

   function automatic logic [19:0] tx_expect(input logic [31:0] w, input logic lsb);
      return lsb ? {w[17:0], 2'b00} : {w[31:14], 2'b00};
   endfunction

   function automatic logic [31:0] rx_expect(input logic [19:0] s, input logic [1:0] m);
      case (m)
         2'd0:    return {s[19:2], 14'h0};
         2'd1:    return {{14{s[19]}}, s[19:2]};
         2'd2:    return {s[19:4], 16'h0};
         default: return {{16{s[19]}}, s[19:4]};
      endcase
   endfunction

   function automatic logic [17:0] mk_ctl(input logic [7:0] txl, input logic [4:0] rxl,
                                          input logic txm, input logic [1:0] rxm);
      return {2'b00, rxm, txm, rxl, txl};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic ctl_write(input logic [17:0] v);
      @(negedge clk);
      ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_we = 1'b0;
      shadow = v & 18'h0FFFF;
   endtask

   task automatic tx_push(input logic [31:0] w, input bit keep);
      @(negedge clk);
      tx_wr_en = 1'b1; tx_wr_data = w;
      @(negedge clk);
      tx_wr_en = 1'b0;
      if (keep) txq.push_back(tx_expect(w, shadow[13]));
   endtask

   task automatic tx_pop_check(input string req);
      @(negedge clk);
      check(req, {12'h0, tx_sample}, {12'h0, txq.pop_front()});
      tx_rd_en = 1'b1;
      @(negedge clk);
      tx_rd_en = 1'b0;
   endtask

   task automatic rx_push(input logic [19:0] s, input bit keep);
      @(negedge clk);
      rx_wr_en = 1'b1; rx_wr_sample = s;
      @(negedge clk);
      rx_wr_en = 1'b0;
      if (keep) rxq.push_back(s);
   endtask

   task automatic rx_pop_check(input string req);
      @(negedge clk);
      check(req, rx_rd_data, rx_expect(rxq.pop_front(), shadow[15:14]));
      rx_rd_en = 1'b1;
      @(negedge clk);
      rx_rd_en = 1'b0;
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      shadow = 18'h00F30;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 reset state
      check("R2 ctl reset", 32'(ctl_rdata), 32'h00F30);
      check("R9 tx empty at reset", 32'(tx_empty), 1);
      check("R9 rx empty at reset", 32'(rx_empty), 1);
      check("R7 tx_req at reset", 32'(tx_req), 1);
      check("R8 rx_req at reset", 32'(rx_req), 0);
      check("R10 flags at reset", {28'h0, tx_overrun, tx_underrun, rx_overrun, rx_underrun}, 0);

      // R7 threshold edge at TX level 48: free >= 48 while count <= 16
      for (int i = 0; i < 16; i++) tx_push(32'hDEAD_BEEF ^ (32'(i) * 32'h0123_4567), 1);
      check("R7 tx_req at 16 stored", 32'(tx_req), 1);
      tx_push(32'h8000_4001, 1);
      check("R7 tx_req at 17 stored", 32'(tx_req), 0);
      for (int i = 17; i < 64; i++) tx_push(32'h5A5A_0000 + (32'(i) * 32'h0003_1C07), 1);
      check("R9 tx full at 64", 32'(tx_full), 1);
      tx_push(32'hFFFF_FFFF, 0);
      check("R10 tx overrun after push to full", 32'(tx_overrun), 1);
      check("R10 tx still full", 32'(tx_full), 1);
      // R3 top-justified unpack, R9 order across full depth
      for (int i = 0; i < 64; i++) tx_pop_check("R3 R9 tx head");
      check("R9 tx empty after draining", 32'(tx_empty), 1);
      check("R10 tx overrun sticky", 32'(tx_overrun), 1);
      @(negedge clk); tx_rd_en = 1'b1;
      @(negedge clk); tx_rd_en = 1'b0;
      check("R11 tx underrun after pop empty", 32'(tx_underrun), 1);
      check("R11 tx still empty", 32'(tx_empty), 1);

      // R4 bottom-justified unpack
      ctl_write(mk_ctl(8'h30, 5'h0F, 1'b1, 2'd0));
      tx_push(32'hFFFC_0001, 1);
      tx_push(32'h0002_ABCD, 1);
      tx_push(32'h1234_5678, 1);
      for (int i = 0; i < 3; i++) tx_pop_check("R4 tx head");

      // R1 TX flush with a push in the flush cycle
      for (int i = 0; i < 5; i++) tx_push(32'hC0DE_0000 + 32'(i), 1);
      @(negedge clk);
      ctl_we = 1'b1; ctl_wdata = shadow | 18'h10000;
      @(negedge clk);
      ctl_we = 1'b0;
      check("R1 tx flush bit visible", 32'(ctl_rdata[16]), 1);
      tx_wr_en = 1'b1; tx_wr_data = 32'h7777_7777;
      @(negedge clk);
      tx_wr_en = 1'b0;
      txq.delete();
      check("R1 tx flush bit cleared", 32'(ctl_rdata[16]), 0);
      check("R1 tx empty after flush", 32'(tx_empty), 1);
      check("R1 tx flags cleared by flush", {30'h0, tx_overrun, tx_underrun}, 0);

      // R5 R6 RX packing modes, negative then positive sample
      rx_push(20'hA5C3F, 1);
      rx_push(20'h31234, 1);
      for (int m = 0; m < 4; m++) begin
         ctl_write(mk_ctl(8'h30, 5'h0F, 1'b0, 2'(m)));
         @(negedge clk);
         check(m < 2 ? "R5 rx pack negative" : "R6 rx pack negative",
               rx_rd_data, rx_expect(20'hA5C3F, 2'(m)));
      end
      rx_pop_check("R6 rx pop negative");
      for (int m = 0; m < 4; m++) begin
         ctl_write(mk_ctl(8'h30, 5'h0F, 1'b0, 2'(m)));
         @(negedge clk);
         check(m < 2 ? "R5 rx pack positive" : "R6 rx pack positive",
               rx_rd_data, rx_expect(20'h31234, 2'(m)));
      end
      rx_pop_check("R9 rx pop positive");

      // R8 RX threshold 15 means trigger at 16
      ctl_write(mk_ctl(8'h30, 5'h0F, 1'b0, 2'd1));
      for (int i = 0; i < 15; i++) rx_push(20'h80000 + 20'(i * 37), 1);
      check("R8 rx_req at 15 stored", 32'(rx_req), 0);
      rx_push(20'h7FFFF, 1);
      check("R8 rx_req at 16 stored", 32'(rx_req), 1);
      for (int i = 16; i < 32; i++) rx_push(20'h01000 + 20'(i * 4099), 1);
      check("R9 rx full at 32", 32'(rx_full), 1);
      rx_push(20'h00001, 0);
      check("R10 rx overrun after push to full", 32'(rx_overrun), 1);
      for (int i = 0; i < 3; i++) rx_pop_check("R9 rx order");
      ctl_write(shadow | 18'h20000);
      @(negedge clk);
      rxq.delete();
      check("R1 rx empty after flush", 32'(rx_empty), 1);
      check("R1 rx flags cleared by flush", 32'(rx_overrun), 0);
      check("R1 rx flush bit cleared", 32'(ctl_rdata[17]), 0);

      // R8 threshold 0 means trigger at 1
      ctl_write(mk_ctl(8'h30, 5'h00, 1'b0, 2'd0));
      check("R8 rx_req empty at level 0", 32'(rx_req), 0);
      rx_push(20'h12345, 1);
      check("R8 rx_req at 1 stored level 0", 32'(rx_req), 1);
      rx_pop_check("R5 rx pop mode 0");
      @(negedge clk); rx_rd_en = 1'b1;
      @(negedge clk); rx_rd_en = 1'b0;
      check("R11 rx underrun after pop empty", 32'(rx_underrun), 1);

      // R7 TX threshold 0 keeps request on when full
      ctl_write(mk_ctl(8'h00, 5'h00, 1'b0, 2'd0));
      for (int i = 0; i < 64; i++) tx_push(32'(i), 1);
      check("R7 tx_req full at level 0", 32'(tx_req), 1);

      summary();
      $finish;
   end
endmodule